// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This block keeps wall-clock time and a calendar date from a slow reference strobe. The strobe runs at 32.768 kHz and is sampled as a one-cycle enable in the system clock domain. A programmable prescaler counts strobes down to a once-per-second tick. A small trim field stretches one second in every window of seconds, which gives a coarse rate correction. Each tick advances a packed time-of-day word and a packed date word in place. Seconds, minutes and hours roll over, days roll over at the month length (including leap Februaries), and months roll over into the year.

One packed alarm time and date pair is compared against the counters on every tick. A status register holds the sticky event flags, which software clears by writing one, together with their enables, which are plain read/write bits. The interrupt output combines each flag with its enable. Software reaches everything through a simple word-addressed write port and a combinational read port. Writing the time or the date takes effect at once and restarts the prescaler.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the status word reads 0, the prescaler word reads 0x00007FFF (divider 32767, trim 0), the time reads 00:00:00, the date reads year 2000, month 1, day 1, the alarm words read 0, and irq is low.
- R2: The prescaler word at offset 0x0C holds the divider D in bits 15:0. With trim 0, a tick occurs on the strobe on which D+1 strobes have been counted since the previous tick or restart, so D=32767 gives 1 Hz from 32.768 kHz.
- R3: The trim value T sits in bits 23:16 of the prescaler word. Ticks are numbered 0 to 7 within a window, and the window restarts with the prescaler. The second that ends in the 8th tick of each window lasts D+1+T strobes.
- R4: The time word at offset 0x10 packs hour in bits 16:12, minute in bits 11:6 and second in bits 5:0. A tick advances the second, which wraps 59→0 into the minute, which wraps 59→0 into the hour, which wraps 23→0. Between ticks and writes the time holds.
- R5: The date word at offset 0x14 packs year in bits 20:9, month in bits 8:5 and day in bits 4:0. When the time wraps past 23:59:59, the day advances. It wraps to 1 after 30 days for months 4, 6, 9 and 11, after 31 days for the other months, and after 29 days for February when the year is divisible by 4 (28 days otherwise). Month 12 wraps to 1 and the year increments.
- R6: On a tick whose new time and date equal the alarm words (time at offset 0x18, date at offset 0x1C, same packing), status bit 0 is set if bit 2 is 1, and status bit 4 is set if bit 5 is 1. An alarm source whose enable is 0 leaves its flag unchanged.
- R7: Status bit 1 is set on every tick.
- R8: In the status word at offset 0x08, writing 1 to flag bits 0, 1 or 4 clears them and writing 0 leaves them. Enable bits 2, 3 and 5 are stored as written. An event in the same cycle as a clear leaves the flag set.
- R9: irq is high exactly when (bit0 AND bit2) OR (bit1 AND bit3) OR (bit4 AND bit5) of the status word.
- R10: A write to the time or date word updates it on that clock edge, suppresses any tick in that cycle and restarts the prescaler and the trim window, so the next tick comes D+1 strobes later.
- R11: The alarm words read back as written, and a read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_strobe | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is the lengthened second. It only appears on the eighth tick after a restart, and it interacts with the prescaler restart that any time or date write causes. The bench first sets a zero divider and a small trim, then writes the time to restart the window at a known edge. From there it counts strobes to the exact edge where the stretched tick must land. Calendar carries, such as the year end and the leap and non-leap Februaries, are reached by writing times one or two seconds before midnight. A behavioural model then follows a long run with irregular strobes and every enable set.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam logic [7:0] OFS_STATUS = 8'h08;
    localparam logic [7:0] OFS_PRESC  = 8'h0C;
    localparam logic [7:0] OFS_TOD    = 8'h10;
    localparam logic [7:0] OFS_DATE   = 8'h14;
    localparam logic [7:0] OFS_AL_TOD = 8'h18;
    localparam logic [7:0] OFS_AL_DAT = 8'h1C;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    typedef struct packed {
        logic [11:0] year;
        logic [3:0]  mon;
        logic [4:0]  day;
    } date_t;

    typedef struct packed {
        logic a1_en;
        logic a1_flag;
        logic hz_en;
        logic al_en;
        logic hz_flag;
        logic al_flag;
    } status_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_STATUS, SEL_PRESC, SEL_TOD, SEL_DATE, SEL_AL_TOD, SEL_AL_DAT
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(logic [7:0] ofs);
        case (ofs)
            OFS_STATUS: return SEL_STATUS;
            OFS_PRESC:  return SEL_PRESC;
            OFS_TOD:    return SEL_TOD;
            OFS_DATE:   return SEL_DATE;
            OFS_AL_TOD: return SEL_AL_TOD;
            OFS_AL_DAT: return SEL_AL_DAT;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [4:0] days_in_month(logic [3:0] mon, logic [11:0] year);
        case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            4'd2:                    return (year[1:0] == 2'd0) ? 5'd29 : 5'd28;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic tod_t tod_step(tod_t t, output logic day_over);
        tod_t n;
        n = t;
        day_over = 1'b0;
        if (t.sec >= 6'd59) begin
            n.sec = '0;
            if (t.min >= 6'd59) begin
                n.min = '0;
                if (t.hour >= 5'd23) begin
                    n.hour   = '0;
                    day_over = 1'b1;
                end else begin
                    n.hour = t.hour + 5'd1;
                end
            end else begin
                n.min = t.min + 6'd1;
            end
        end else begin
            n.sec = t.sec + 6'd1;
        end
        return n;
    endfunction

    function automatic date_t date_step(date_t d);
        date_t n;
        n = d;
        if (d.day >= days_in_month(d.mon, d.year)) begin
            n.day = 5'd1;
            if (d.mon >= 4'd12) begin
                n.mon  = 4'd1;
                n.year = d.year + 12'd1;
            end else begin
                n.mon = d.mon + 4'd1;
            end
        end else begin
            n.day = d.day + 5'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_cal_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int TRIM_W   = 8,
    parameter int WIN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              restart,
    input  logic [DIV_W-1:0]  divider,
    input  logic [TRIM_W-1:0] trim,
    output logic              tick
);
    localparam int CNT_W = ((DIV_W > TRIM_W) ? DIV_W : TRIM_W) + 1;

    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    limit;
    logic [WIN_LOG2-1:0] win_q;

    // The last second of every window is stretched by the trim amount
    always_comb begin
        limit = CNT_W'(divider) + ((&win_q) ? CNT_W'(trim) : CNT_W'(0));
        tick  = strobe && !restart && (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            win_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            win_q <= win_q + 1'b1;
        end else if (strobe) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_tick_reaches_div_R2: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt_q >= CNT_W'(divider)));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int RESET_YEAR = 2000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  wr_tod,
    input  logic  wr_date,
    input  tod_t  tod_wval,
    input  date_t date_wval,
    output tod_t  tod_q,
    output date_t date_q,
    output tod_t  tod_nx,
    output date_t date_nx
);
    logic day_over;

    always_comb begin
        tod_nx  = tod_step(tod_q, day_over);
        date_nx = day_over ? date_step(date_q) : date_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_q  <= '0;
            date_q <= '{year: 12'(RESET_YEAR), mon: 4'd1, day: 5'd1};
        end else begin
            if (wr_tod)
                tod_q <= tod_wval;
            else if (tick)
                tod_q <= tod_nx;
            if (wr_date)
                date_q <= date_wval;
            else if (tick)
                date_q <= date_nx;
        end
    end

    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_tod && !wr_date) |=> ($stable(tod_q) && $stable(date_q)));

endmodule

// File: rtl/rtc_events.sv
module rtc_events
    import rtc_cal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    match,
    input  logic    st_wr,
    input  status_t st_wval,
    output status_t status_q,
    output logic    irq
);
    // Event set wins over a same-cycle clear; enables use the value held before the write
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q.al_flag <= (status_q.al_flag & ~(st_wr & st_wval.al_flag))
                                | (match & status_q.al_en);
            status_q.a1_flag <= (status_q.a1_flag & ~(st_wr & st_wval.a1_flag))
                                | (match & status_q.a1_en);
            status_q.hz_flag <= (status_q.hz_flag & ~(st_wr & st_wval.hz_flag)) | tick;
            if (st_wr) begin
                status_q.al_en <= st_wval.al_en;
                status_q.hz_en <= st_wval.hz_en;
                status_q.a1_en <= st_wval.a1_en;
            end
        end
    end

    always_comb begin
        irq = (status_q.al_flag & status_q.al_en)
            | (status_q.hz_flag & status_q.hz_en)
            | (status_q.a1_flag & status_q.a1_en);
    end

    assert_alarm_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_q.al_flag) || $rose(status_q.a1_flag)) |-> $past(tick));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (st_wr && st_wval.al_flag && !match) |=> !status_q.al_flag);

    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_q.al_flag || status_q.hz_flag || status_q.a1_flag));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int TRIM_W     = 8,
    parameter int WIN_LOG2   = 3,
    parameter int DEF_DIV    = 32767,
    parameter int RESET_YEAR = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_strobe,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int TRIM_LSB = 16;

    reg_sel_e          sel;
    logic              wr_tod, wr_date, wr_status;
    logic [DIV_W-1:0]  div_q;
    logic [TRIM_W-1:0] trim_q;
    tod_t              al_tod_q, tod_q, tod_nx;
    date_t             al_date_q, date_q, date_nx;
    status_t           status_q;
    logic              tick, match;

    always_comb begin
        sel       = decode_ofs(bus_addr);
        wr_tod    = bus_wr && (sel == SEL_TOD);
        wr_date   = bus_wr && (sel == SEL_DATE);
        wr_status = bus_wr && (sel == SEL_STATUS);
        match     = tick && (tod_nx == al_tod_q) && (date_nx == al_date_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= DIV_W'(DEF_DIV);
            trim_q    <= '0;
            al_tod_q  <= '0;
            al_date_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_PRESC: begin
                    div_q  <= bus_wdata[DIV_W-1:0];
                    trim_q <= bus_wdata[TRIM_LSB +: TRIM_W];
                end
                SEL_AL_TOD: al_tod_q  <= tod_t'(bus_wdata[$bits(tod_t)-1:0]);
                SEL_AL_DAT: al_date_q <= date_t'(bus_wdata[$bits(date_t)-1:0]);
                default: ;
            endcase
        end
    end

    rtc_prescaler #(.DIV_W(DIV_W), .TRIM_W(TRIM_W), .WIN_LOG2(WIN_LOG2)) u_presc (
        .clk(clk), .rst(rst), .strobe(ref_strobe), .restart(wr_tod || wr_date),
        .divider(div_q), .trim(trim_q), .tick(tick)
    );

    rtc_calendar #(.RESET_YEAR(RESET_YEAR)) u_cal (
        .clk(clk), .rst(rst), .tick(tick), .wr_tod(wr_tod), .wr_date(wr_date),
        .tod_wval(tod_t'(bus_wdata[$bits(tod_t)-1:0])),
        .date_wval(date_t'(bus_wdata[$bits(date_t)-1:0])),
        .tod_q(tod_q), .date_q(date_q), .tod_nx(tod_nx), .date_nx(date_nx)
    );

    rtc_events u_evt (
        .clk(clk), .rst(rst), .tick(tick), .match(match), .st_wr(wr_status),
        .st_wval(status_t'(bus_wdata[$bits(status_t)-1:0])),
        .status_q(status_q), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_STATUS: bus_rdata = 32'(status_q);
            SEL_PRESC:  bus_rdata = 32'(div_q) | (32'(trim_q) << TRIM_LSB);
            SEL_TOD:    bus_rdata = 32'(tod_q);
            SEL_DATE:   bus_rdata = 32'(date_q);
            SEL_AL_TOD: bus_rdata = 32'(al_tod_q);
            SEL_AL_DAT: bus_rdata = 32'(al_date_q);
            default:    bus_rdata = '0;
        endcase
    end

    assert_no_tick_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_tod || wr_date) |-> !tick);

endmodule

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
module rtc_calendar_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_strobe = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0, cmp_on = 0;
    int strobe_mode = 0;

    always #2 clk = ~clk;

    rtc_calendar_core u_rtc_calendar_core (
        .clk(clk), .rst(rst), .ref_strobe(ref_strobe), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_div, m_trim, m_cnt, m_win;
    int a_sec, a_min, a_hour, a_day, a_mon, a_year;
    bit f_al, f_hz, f_a1, e_al, e_hz, e_a1;

    function automatic int mdays(int mon, int yr);
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    function automatic logic [31:0] mread(logic [7:0] a);
        case (a)
            8'h08: return {26'd0, e_a1, f_a1, e_hz, e_al, f_hz, f_al};
            8'h0C: return 32'((m_trim << 16) + m_div);
            8'h10: return 32'((m_hour << 12) + (m_min << 6) + m_sec);
            8'h14: return 32'((m_year << 9) + (m_mon << 5) + m_day);
            8'h18: return 32'((a_hour << 12) + (a_min << 6) + a_sec);
            8'h1C: return 32'((a_year << 9) + (a_mon << 5) + a_day);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(logic [7:0] a);
        case (a)
            8'h08: return "R8";
            8'h0C: return "R2";
            8'h10: return "R4";
            8'h14: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mon = 1; m_year = 2000;
        m_div = 32767; m_trim = 0; m_cnt = 0; m_win = 0;
        a_sec = 0; a_min = 0; a_hour = 0; a_day = 0; a_mon = 0; a_year = 0;
        {f_al, f_hz, f_a1, e_al, e_hz, e_a1} = '0;
    endtask

    task automatic model_step();
        bit restart, tk, hit;
        int lim;
        int d;
        restart = bus_wr && (bus_addr == 8'h10 || bus_addr == 8'h14);
        lim = m_div + ((m_win == 7) ? m_trim : 0);
        tk = ref_strobe && !restart && (m_cnt >= lim);
        if (restart) begin m_cnt = 0; m_win = 0; end
        else if (tk) begin m_cnt = 0; m_win = (m_win + 1) % 8; end
        else if (ref_strobe) m_cnt++;
        hit = 0;
        if (tk) begin
            m_sec++;
            if (m_sec == 60) begin m_sec = 0; m_min++; end
            if (m_min == 60) begin m_min = 0; m_hour++; end
            if (m_hour == 24) begin
                m_hour = 0; m_day++;
                if (m_day > mdays(m_mon, m_year)) begin m_day = 1; m_mon++; end
                if (m_mon > 12) begin m_mon = 1; m_year = (m_year + 1) % 4096; end
            end
            hit = (m_sec == a_sec && m_min == a_min && m_hour == a_hour &&
                   m_day == a_day && m_mon == a_mon && m_year == a_year);
        end
        d = int'(bus_wdata);
        if (bus_wr && bus_addr == 8'h08) begin
            if (bus_wdata[0]) f_al = 0;
            if (bus_wdata[1]) f_hz = 0;
            if (bus_wdata[4]) f_a1 = 0;
        end
        if (hit && e_al) f_al = 1;
        if (hit && e_a1) f_a1 = 1;
        if (tk) f_hz = 1;
        if (bus_wr) begin
            case (bus_addr)
                8'h08: begin e_al = bus_wdata[2]; e_hz = bus_wdata[3]; e_a1 = bus_wdata[5]; end
                8'h0C: begin m_div = d & 16'hFFFF; m_trim = (d >> 16) & 8'hFF; end
                8'h10: begin m_hour = (d >> 12) & 31; m_min = (d >> 6) & 63; m_sec = d & 63; end
                8'h14: begin m_year = (d >> 9) & 12'hFFF; m_mon = (d >> 5) & 15; m_day = d & 31; end
                8'h18: begin a_hour = (d >> 12) & 31; a_min = (d >> 6) & 63; a_sec = d & 63; end
                8'h1C: begin a_year = (d >> 9) & 12'hFFF; a_mon = (d >> 5) & 15; a_day = d & 31; end
                default: ;
            endcase
        end
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, sampled 1 ns after the edge
    always @(posedge clk) begin
        if (rst) model_reset();
        else model_step();
        #1;
        if (cmp_on && !rst && !done) begin
            check("R9 irq", {31'd0, irq}, {31'd0, (f_al & e_al) | (f_hz & e_hz) | (f_a1 & e_a1)});
            check(req_of(bus_addr), bus_rdata, mread(bus_addr));
        end
    end

    // reference strobe source
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ref_strobe = (strobe_mode == 1) || (strobe_mode == 2 && lfsr[0]);
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_addr = 8'h08 + 8'((i % 6) * 4);
        end
    endtask

    function automatic logic [31:0] tpack(int h, int m, int s);
        return 32'((h << 12) + (m << 6) + s);
    endfunction
    function automatic logic [31:0] dpack(int y, int mo, int dd);
        return 32'((y << 9) + (mo << 5) + dd);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rd(8'h08, 32'h0, "R1 status");
        rd(8'h0C, 32'h00007FFF, "R1 prescaler");
        rd(8'h10, 32'h0, "R1 time");
        rd(8'h14, dpack(2000, 1, 1), "R1 date");
        rd(8'h18, 32'h0, "R1 alarm time");
        check("R1 irq", {31'd0, irq}, 32'd0);
        cmp_on = 1;

        // R2 divider 3 -> four strobes per second
        strobe_mode = 1;
        wr(8'h0C, 32'h0000_0003);
        rd(8'h0C, 32'h0000_0003, "R2 divider readback");
        wr(8'h14, dpack(2023, 12, 31));
        wr(8'h10, tpack(23, 59, 58));
        idle(2);
        rd(8'h10, tpack(23, 59, 58), "R10 no tick before full second");
        idle(7);
        rd(8'h10, tpack(0, 0, 0), "R4 midnight rollover");
        rd(8'h14, dpack(2024, 1, 1), "R5 year rollover");

        // R5 leap and non-leap February, 30-day month
        wr(8'h14, dpack(2024, 2, 28)); wr(8'h10, tpack(23, 59, 59)); idle(5);
        rd(8'h14, dpack(2024, 2, 29), "R5 leap Feb 29");
        wr(8'h14, dpack(2023, 2, 28)); wr(8'h10, tpack(23, 59, 59)); idle(5);
        rd(8'h14, dpack(2023, 3, 1), "R5 non-leap Feb");
        wr(8'h14, dpack(2023, 4, 30)); wr(8'h10, tpack(23, 59, 59)); idle(5);
        rd(8'h14, dpack(2023, 5, 1), "R5 30-day month");

        // R6/R7/R8/R9 alarm and status
        wr(8'h08, 32'h13);           // clear all flags, only the bit-0 alarm source enabled
        wr(8'h08, 32'h04);
        wr(8'h18, tpack(10, 20, 32));
        wr(8'h1C, dpack(2024, 6, 15));
        rd(8'h18, tpack(10, 20, 32), "R11 alarm time readback");
        rd(8'h1C, dpack(2024, 6, 15), "R11 alarm date readback");
        rd(8'h04, 32'h0, "R11 unmapped read");
        wr(8'h14, dpack(2024, 6, 15));
        wr(8'h10, tpack(10, 20, 30));
        idle(5);
        rd(8'h08, 32'h06, "R7 hz flag, alarm not yet");
        check("R9 irq low", {31'd0, irq}, 32'd0);
        idle(4);
        rd(8'h08, 32'h07, "R6 alarm flag set, disabled source ignored");
        check("R9 irq high", {31'd0, irq}, 32'd1);
        wr(8'h08, 32'h07);
        rd(8'h08, 32'h04, "R8 write-one clears flags, enable kept");
        wr(8'h08, 32'h08);
        idle(5);
        rd(8'h08, 32'h0A, "R7 hz flag with hz enable");
        check("R9 irq from hz", {31'd0, irq}, 32'd1);

        // R3 trim: divider 0, trim 2, window restarted by a time write
        wr(8'h0C, 32'h0002_0000);
        wr(8'h10, tpack(0, 0, 0));
        idle(8);
        rd(8'h10, tpack(0, 0, 7), "R3 seven short seconds");
        @(negedge clk);
        rd(8'h10, tpack(0, 0, 7), "R3 stretched second pending");
        @(negedge clk);
        rd(8'h10, tpack(0, 0, 8), "R3 stretched second done");

        // long irregular run against the model
        wr(8'h0C, 32'h0003_0002);
        wr(8'h08, 32'h3F);
        wr(8'h18, tpack(0, 1, 10));
        wr(8'h1C, dpack(2024, 12, 31));
        wr(8'h14, dpack(2024, 12, 31));
        wr(8'h10, tpack(0, 0, 50));
        strobe_mode = 2;
        idle(3000);
        wr(8'h08, 32'h13);
        idle(200);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule